// File: doc/BRIEF.md
# BERT Receive Status Register

This block holds the status and alarm flags of a bit-error-rate tester receiver. The pattern synchronizer, the bit counter and the error counter sit outside it. They report to it through level and pulse inputs. The block also watches the received bit stream itself. In pseudorandom mode it flags a run of 40 identical bits, either all ones or all zeros, as a stuck line.

Software reads the flags through one 8-bit register at address 4h, and a read clears them. Each bit has its own clearing rule:

- Overflow flags always clear on a read.
- Condition flags (the two stuck-line alarms, the error-present flag and the loss-of-sync flag) clear on a read only if their condition has ended.
- The lock indication is not latched at all. It follows the synchronizer directly.

A set request that arrives in the same cycle as a clearing read wins, so no event is lost.

The read data is combinational. It shows the flags as they stand before the clearing edge.

Top module: `bert_status_reg`

## Requirements
- R1: During and directly after reset every latched flag is 0, so a read of address 4h returns only the live lock bit.
- R2: `rd_data_o` shows the status byte only while `rd_addr_i` is 4h and is 0 for any other address. A read strobe at another address clears nothing.
- R3: Bit 6 (all-ones alarm) sets when 40 consecutive valid received bits are 1 in pseudorandom mode. It reads 1 from the second rising edge after the 40th bit is sampled. A run of 39 ones does not set it.
- R4: Bit 5 (all-zeros alarm) follows the same rule as R3 for runs of received 0 bits.
- R5: A read clears bit 6 or bit 5 only after the run has been broken by an opposite bit. A read while the run still holds leaves the bit set. Breaking the run alone does not clear the bit.
- R6: Only cycles with `rx_valid_i` high and `prbs_mode_i` high count toward a run. Invalid cycles pause the count. Leaving pseudorandom mode restarts it from zero.
- R7: Bit 4 (errors present) sets while `err_cnt_nz_i` is high. A read clears it only once that input is low.
- R8: Bit 3 (error-counter overflow) and bit 2 (bit-counter overflow) set one cycle after their input pulse. A read clears them, and they stay clear until a new pulse arrives.
- R9: Bit 1 (loss of sync) sets while `sync_i` is low. It stays set after `sync_i` rises until a read made while `sync_i` is high.
- R10: Bit 0 equals `sync_i` in the same cycle, with no latching.
- R11: A set request in the same cycle as a clearing read leaves the flag set after that edge.
- R12: Bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prbs_mode_i | input | 1 | Receiver is in pseudorandom pattern mode |
| rx_valid_i | input | 1 | `rx_bit_i` carries a received bit this cycle |
| rx_bit_i | input | 1 | Received data bit |
| sync_i | input | 1 | Synchronizer locked (high) or searching (low) |
| err_cnt_nz_i | input | 1 | Bit error count is nonzero |
| err_ovf_i | input | 1 | Error counter overflow pulse |
| bit_ovf_i | input | 1 | Bit counter overflow pulse |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 8 | Status byte at address 4h, otherwise 0 |

## Verification
The bench sends runs of exactly 39 and exactly 40 identical bits. An off-by-one run counter would raise the alarm one bit early or one bit late.

It reads a stuck-line alarm while the run still holds. A design that clears condition flags without checking the condition would drop the alarm on that read.

It also checks:

- A read that coincides with an overflow pulse. A design that gives the read priority would lose that event.
- A read strobe at a neighbouring address. A design with a loose address decode would clear flags it should not touch.
- Gaps in the valid strobe and a brief exit from pseudorandom mode. These separate a design that pauses the count on invalid cycles, and restarts it on a mode exit, from one that miscounts.

// File: rtl/bert_stat_pkg.sv
package bert_stat_pkg;
  // index of each latched flag; read bit = index + 1, bit 0 is live sync
  localparam int unsigned L_RLOS  = 0;
  localparam int unsigned L_BCOF  = 1;
  localparam int unsigned L_BECOF = 2;
  localparam int unsigned L_BED   = 3;
  localparam int unsigned L_RA0   = 4;
  localparam int unsigned L_RA1   = 5;
  localparam int unsigned N_LATCH = 6;
  localparam int unsigned DATA_W  = 8;
endpackage

// File: rtl/bert_run_detect.sv
module bert_run_detect #(
  parameter int unsigned RUN_LEN = 40,
  parameter bit          MATCH   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic valid_i,
  input  logic bit_i,
  output logic hit_o
);
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else if (valid_i) begin
      if (bit_i != MATCH)       cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/bert_latch_bits.sv
module bert_latch_bits #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  // set beats clear: a condition still present or a new event keeps the flag
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[i] <= 1'b0;
      else         q_o[i] <= set_i[i] | (q_o[i] & ~clr_i);
    end
  end
endmodule

// File: rtl/bert_status_reg.sv
module bert_status_reg
  import bert_stat_pkg::*;
#(
  parameter int unsigned RUN_LEN   = 40,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned STAT_ADDR = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prbs_mode_i,
  input  logic              rx_valid_i,
  input  logic              rx_bit_i,
  input  logic              sync_i,
  input  logic              err_cnt_nz_i,
  input  logic              err_ovf_i,
  input  logic              bit_ovf_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(STAT_ADDR);

  logic               addr_hit;
  logic               rd_hit;
  logic               ones_hit;
  logic               zeros_hit;
  logic [N_LATCH-1:0] lat_set;
  logic [N_LATCH-1:0] lat_q;

  assign addr_hit = (rd_addr_i == SEL);
  assign rd_hit   = rd_en_i & addr_hit;

  for (genvar p = 0; p < 2; p++) begin : g_run
    logic hit;
    bert_run_detect #(
      .RUN_LEN (RUN_LEN),
      .MATCH   (p == 1)
    ) u_run (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (prbs_mode_i),
      .valid_i (rx_valid_i),
      .bit_i   (rx_bit_i),
      .hit_o   (hit)
    );
  end
  assign zeros_hit = g_run[0].hit;
  assign ones_hit  = g_run[1].hit;

  always_comb begin
    lat_set          = '0;
    lat_set[L_RLOS]  = ~sync_i;
    lat_set[L_BCOF]  = bit_ovf_i;
    lat_set[L_BECOF] = err_ovf_i;
    lat_set[L_BED]   = err_cnt_nz_i;
    lat_set[L_RA0]   = zeros_hit;
    lat_set[L_RA1]   = ones_hit;
  end

  bert_latch_bits #(.N(N_LATCH)) u_lat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (lat_set),
    .clr_i  (rd_hit),
    .q_o    (lat_q)
  );

  assign rd_data_o = addr_hit ? {1'b0, lat_q, sync_i} : '0;
endmodule

module bert_status_chk
  import bert_stat_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sync_i,
  input logic               err_cnt_nz_i,
  input logic               err_ovf_i,
  input logic               bit_ovf_i,
  input logic               rd_hit,
  input logic [N_LATCH-1:0] lat_q
);
  a_r8_becof_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ovf_i |=> lat_q[L_BECOF]);
  a_r8_bcof_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && !bit_ovf_i) |=> !lat_q[L_BCOF]);
  a_r8_bcof_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q[L_BCOF] && !rd_hit) |=> lat_q[L_BCOF]);
  a_r9_rlos_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> lat_q[L_RLOS]);
  a_r7_bed_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt_nz_i |=> lat_q[L_BED]);
  a_r3_runs_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($rose(lat_q[L_RA1]) && $rose(lat_q[L_RA0])));
endmodule

bind bert_status_reg bert_status_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sync_i       (sync_i),
  .err_cnt_nz_i (err_cnt_nz_i),
  .err_ovf_i    (err_ovf_i),
  .bit_ovf_i    (bit_ovf_i),
  .rd_hit       (rd_hit),
  .lat_q        (lat_q)
);

// File: tb/tb_bert_status_reg.sv
module tb_bert_status_reg;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NVEC = 21;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       prbs_mode_i = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic       rx_bit_i = 1'b0;
  logic       sync_i = 1'b1;
  logic       err_cnt_nz_i = 1'b0;
  logic       err_ovf_i = 1'b0;
  logic       bit_ovf_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [3:0] rd_addr_i = 4'h4;
  logic [7:0] rd_data_o;

  int checks = 0;
  int errors = 0;

  bert_status_reg dut (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  // {rd, addr, err_nz, err_ovf, bit_ovf, sync, expected read byte before edge}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 4'h4, 4'b0001, 8'h01},  // R1
    {1'b0, 4'h4, 4'b0000, 8'h00},  // R10 sync low
    {1'b0, 4'h4, 4'b0001, 8'h03},  // R9 set
    {1'b1, 4'h4, 4'b0001, 8'h03},  // R9 read, sync up
    {1'b0, 4'h4, 4'b0001, 8'h01},  // R9 cleared
    {1'b0, 4'h4, 4'b0011, 8'h01},  // bit overflow pulse
    {1'b0, 4'h4, 4'b0001, 8'h05},  // R8
    {1'b1, 4'h5, 4'b0001, 8'h00},  // R2 other addr
    {1'b0, 4'h4, 4'b0001, 8'h05},  // R2 not cleared
    {1'b1, 4'h4, 4'b0001, 8'h05},  // R8 read
    {1'b0, 4'h4, 4'b0001, 8'h01},  // R8 stays clear
    {1'b1, 4'h4, 4'b0101, 8'h01},  // R11 pulse with read
    {1'b0, 4'h4, 4'b0001, 8'h09},  // R11 kept
    {1'b0, 4'h4, 4'b1001, 8'h09},  // R7 error count nz
    {1'b1, 4'h4, 4'b1001, 8'h19},  // R7 read while nz
    {1'b0, 4'h4, 4'b0001, 8'h11},  // R7 kept, R8 becof cleared
    {1'b1, 4'h4, 4'b0001, 8'h11},  // R7 read after nz gone
    {1'b0, 4'h4, 4'b0001, 8'h01},  // R7 cleared
    {1'b0, 4'h4, 4'b0000, 8'h00},  // R10 live low
    {1'b1, 4'h4, 4'b0000, 8'h02},  // R9 read while searching
    {1'b0, 4'h4, 4'b0001, 8'h03}   // R9 kept, R10 live high
  };

  task automatic check(input string req, input logic [7:0] mask, input logic [7:0] exp);
    checks++;
    if ((rd_data_o & mask) !== (exp & mask)) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h (mask %02h)", req, rd_data_o & mask, exp & mask, mask);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic send(input logic b, input int n);
    for (int i = 0; i < n; i++) begin
      rx_valid_i = 1'b1;
      rx_bit_i = b;
      tick();
    end
    rx_valid_i = 1'b0;
  endtask

  task automatic rd_clear();
    rd_en_i = 1'b1;
    tick();
    rd_en_i = 1'b0;
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    check("R1 in reset", 8'hff, 8'h01);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      {rd_en_i, rd_addr_i, err_cnt_nz_i, err_ovf_i, bit_ovf_i, sync_i} = VEC[v][16:8];
      #1;
      check($sformatf("vec %0d (R12 msb)", v), 8'hff, VEC[v][7:0]);
      tick();
    end
    {rd_en_i, err_cnt_nz_i, err_ovf_i, bit_ovf_i} = '0;
    rd_addr_i = 4'h4;
    sync_i = 1'b1;
    rd_clear();
    check("R9 clear before run tests", 8'hff, 8'h01);

    // R3 boundary
    prbs_mode_i = 1'b1;
    send(1'b1, 39);
    tick(); tick(); #1;
    check("R3 39 ones", 8'h60, 8'h00);
    send(1'b1, 1);
    tick(); #1;
    check("R3 40 ones", 8'h60, 8'h40);
    // R5 read while run holds
    rd_clear();
    check("R5 read during run", 8'h60, 8'h40);
    send(1'b0, 1);
    tick(); #1;
    check("R5 broken not read", 8'h60, 8'h40);
    rd_clear();
    check("R5 read after break", 8'h60, 8'h00);

    // R4 boundary
    send(1'b1, 1);
    send(1'b0, 39);
    tick(); tick(); #1;
    check("R4 39 zeros", 8'h60, 8'h00);
    send(1'b0, 1);
    tick(); #1;
    check("R4 40 zeros", 8'h60, 8'h20);
    send(1'b1, 1);
    rd_clear();
    check("R4 cleared after break", 8'h60, 8'h00);

    // R6 valid gaps pause the count
    send(1'b1, 20);
    tick(); tick(); tick();
    send(1'b1, 20);
    tick(); #1;
    check("R6 run across gaps", 8'h60, 8'h40);
    send(1'b0, 1);
    rd_clear();
    check("R6 clear", 8'h60, 8'h00);
    // R6 mode exit restarts
    send(1'b1, 20);
    prbs_mode_i = 1'b0;
    tick();
    prbs_mode_i = 1'b1;
    send(1'b1, 20);
    tick(); tick(); #1;
    check("R6 mode exit restarts", 8'h60, 8'h00);
    prbs_mode_i = 1'b0;
    send(1'b1, 50);
    tick(); tick(); #1;
    check("R6 ignored outside prbs mode", 8'h60, 8'h00);

    // R1 mid-run reset
    bit_ovf_i = 1'b1;
    err_ovf_i = 1'b1;
    tick();
    bit_ovf_i = 1'b0;
    err_ovf_i = 1'b0;
    #1;
    check("R8 both overflows", 8'hff, 8'h0d);
    rst_ni = 1'b0;
    #1;
    check("R1 reset clears", 8'hff, 8'h01);
    tick();
    rst_ni = 1'b1;
    tick(); #1;
    check("R1 after reset", 8'hff, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule